// File: doc/BRIEF.md
# Two-Wire Slave Front End with Function Preamble Routing

This block is the slave side of an I2C/SMBus-style two-wire bus. It oversamples the bus clock and data lines in a fast system clock domain and detects START and STOP conditions. It shifts in the address byte and reads its upper four bits as a function preamble. The preamble picks one of three internal back ends: a temperature-register port, a memory port or a utility-command port. Below the preamble, three select bits must match the board strap pins for the temperature and memory functions. For the utility function those three bits instead carry a command code. The lowest address bit gives the transfer direction.

Once the slave accepts an address, it acknowledges every written byte and hands each one to the selected back end with a strobe. On reads it fetches bytes from the selected back end and shifts them out MSB first through an open-drain enable. It keeps sending for as long as the master acknowledges. While the memory reports a non-volatile write in progress, the slave refuses every address, which lets the master poll for the end of that write. A repeated START drops the current transfer and begins a new address phase at once. A master uses this to follow a pointer write with a read.

Top module: `twowire_preamble_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Until the first START, clocked bus traffic draws no acknowledge and no back-end strobe.
- R2: A START seen in any state, including mid-byte, discards the transfer in progress, clears `be_sel` and begins a new address phase. Bytes already completed remain delivered.
- R3: The address byte is split into preamble b7..b4, select b3..b1 and direction b0 (1 = read). The accepted preambles are: 0011 with b3..b1 equal to `dev_sel[2:0]` selects the temperature port (`be_sel` = 001). 1010 with the same pin match selects the memory port (`be_sel` = 010). 0110 with any b3..b1 selects the utility port (`be_sel` = 100). Every other address gets no acknowledge, and the slave stays silent until the next START.
- R4: The acknowledge (`sda_oe` = 1) starts after the SCL fall that follows the eighth bit. It is released after the SCL fall that ends the ninth clock.
- R5: SDA is sampled on SCL rising edges. `sda_oe` changes only while SCL is low. `sda_oe` = 1 pulls the line low (a 0 bit), and 0 releases it (a 1 bit).
- R6: In a write, every data byte is acknowledged. Each byte is presented on `wr_data` (first bit received = bit 7) with a one-cycle pulse on the selected bit of `be_wr_stb`. `wr_first` is 1 only for the first data byte after the address.
- R7: In a read, the slave takes a byte from the selected lane of `be_rdata` (lane i = bits 8i+7..8i, with temperature = 0, memory = 1, utility = 2) and pulses that port's `be_rd_stb`. It sends the byte MSB first. A master ACK fetches the next byte. After a master NoACK the slave releases SDA and goes idle.
- R8: While `nv_busy` is 1, no address is acknowledged.
- R9: A STOP releases SDA, clears `be_sel` and returns to idle. It pulses `be_stop` for one cycle only if a port was selected.
- R10: `addr_code` holds bits b3..b0 of the last accepted address byte (the command code for the utility port).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel | input | 3 | Strap pin levels matched against b3..b1 |
| nv_busy | input | 1 | Memory non-volatile write in progress |
| be_sel | output | 3 | One-hot selected back end (temp, memory, utility) |
| be_wr_stb | output | 3 | Per-port written-byte strobe |
| be_rd_stb | output | 3 | Per-port read-byte fetch strobe |
| wr_data | output | 8 | Last received data byte |
| wr_first | output | 1 | Marks the first data byte of a write |
| be_rdata | input | 24 | Read byte lanes, one per port |
| addr_code | output | 4 | b3..b0 of the accepted address |
| be_stop | output | 1 | STOP ended a selected transfer |

## Verification
The embedded properties check the following on every cycle. A START always lands in a fresh address phase. A STOP always leaves the line released with nothing selected. The open-drain enable never moves while SCL is high. A busy memory never lets an address through to the acknowledge state. The bit counter never passes a full byte. Only the bench scenarios can show the rest. These include byte contents and bit order in both directions, the decode of each preamble against the strap pins, and `wr_first` marking. They also cover reads that continue on master ACK, a repeated START used for a selective read, and silence on traffic sent before any START.

// File: rtl/tw_pkg.sv
// Shared types and constants for the two-wire slave front end.
// Assumes byte-wide bus transfers and three fixed back-end ports.
package tw_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_PORTS = 3;
    localparam int PORT_TEMP = 0;
    localparam int PORT_MEM  = 1;
    localparam int PORT_UTIL = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_WAIT_MACK
    } tw_state_t;
endpackage

// File: rtl/tw_sync_edge.sv
// Multi-flop synchroniser for one bus line plus a history flop.
// Assumes STAGES >= 2; both lines use equal depth so their relative order is kept.
// Resets to 1, the idle level of a pulled-up bus.
module tw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic prev
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous pin level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin};
    end

    assign lvl = chain[STAGES-1];

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= lvl;
    end
endmodule

// File: rtl/tw_addr_decode.sv
// Combinational address-byte decoder: preamble b7..b4 selects a function,
// b3..b1 must match the strap pins for temperature and memory, and carry
// a free command code for the utility function. A busy memory blocks all.
module tw_addr_decode
    import tw_pkg::*;
#(
    parameter logic [3:0] PRE_TEMP = 4'b0011,
    parameter logic [3:0] PRE_MEM  = 4'b1010,
    parameter logic [3:0] PRE_UTIL = 4'b0110
) (
    input  logic [BYTE_W-1:0]    addr_byte,
    input  logic [2:0]           dev_sel,
    input  logic                 nv_busy,
    output logic [NUM_PORTS-1:0] hit,
    output logic                 ack
);
    logic [3:0] pre;
    logic       pins_ok;

    assign pre     = addr_byte[7:4];
    assign pins_ok = (addr_byte[3:1] == dev_sel);

    // Produce a one-hot port hit from the preamble and pin match.
    always_comb begin
        hit            = '0;
        hit[PORT_TEMP] = (pre == PRE_TEMP) && pins_ok;
        hit[PORT_MEM]  = (pre == PRE_MEM)  && pins_ok;
        hit[PORT_UTIL] = (pre == PRE_UTIL);
    end

    assign ack = (|hit) && !nv_busy;
endmodule

// File: rtl/tw_frame_fsm.sv
// Byte framing state machine for the two-wire slave. Consumes synchronised
// line levels with one cycle of history, detects START/STOP and SCL edges,
// shifts address and data, drives ACK and read bits via an open-drain enable.
// Assumes SCL stays in each phase for several system clocks.
module tw_frame_fsm
    import tw_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_s,
    input  logic                        scl_q,
    input  logic                        sda_s,
    input  logic                        sda_q,
    input  logic [NUM_PORTS-1:0]        dec_hit,
    input  logic                        dec_ack,
    input  logic                        nv_busy,
    input  logic [NUM_PORTS*BYTE_W-1:0] be_rdata,
    output logic [BYTE_W-1:0]           addr_byte,
    output logic                        sda_oe,
    output logic [NUM_PORTS-1:0]        be_sel,
    output logic [NUM_PORTS-1:0]        be_wr_stb,
    output logic [NUM_PORTS-1:0]        be_rd_stb,
    output logic [BYTE_W-1:0]           wr_data,
    output logic                        wr_first,
    output logic [3:0]                  addr_code,
    output logic                        be_stop
);
    localparam int               CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    tw_state_t         state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic [BYTE_W-1:0] rd_byte;
    logic              rw;
    logic              first;
    logic              mack;

    logic scl_rise, scl_fall, start_evt, stop_evt;

    // Decode bus events from current and previous synchronised levels.
    always_comb begin
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
        start_evt = scl_s && scl_q && sda_q && !sda_s;
        stop_evt  = scl_s && scl_q && !sda_q && sda_s;
    end

    // Pick the read byte lane of the selected back end.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (be_sel[i]) rd_byte = rd_byte | be_rdata[i*BYTE_W +: BYTE_W];
        end
    end

    assign addr_byte = shreg;

    // Main framing sequencer: START/STOP first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txsh      <= '0;
            rw        <= 1'b0;
            first     <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            be_sel    <= '0;
            be_wr_stb <= '0;
            be_rd_stb <= '0;
            wr_data   <= '0;
            wr_first  <= 1'b0;
            addr_code <= '0;
            be_stop   <= 1'b0;
        end else begin
            be_wr_stb <= '0;
            be_rd_stb <= '0;
            be_stop   <= 1'b0;
            if (start_evt) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                be_sel <= '0;
            end else if (stop_evt) begin
                state   <= ST_IDLE;
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
                be_stop <= |be_sel;
                be_sel  <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                    end
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CNT_FULL) begin
                            if (dec_ack) begin
                                state     <= ST_ACK;
                                sda_oe    <= 1'b1;
                                be_sel    <= dec_hit;
                                rw        <= shreg[0];
                                addr_code <= shreg[3:0];
                                first     <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                state     <= ST_TX;
                                txsh      <= rd_byte;
                                sda_oe    <= !rd_byte[BYTE_W-1];
                                be_rd_stb <= be_sel;
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CNT_FULL) begin
                            be_wr_stb <= be_sel;
                            wr_data   <= shreg;
                            wr_first  <= first;
                            first     <= 1'b0;
                            sda_oe    <= 1'b1;
                            state     <= ST_ACK;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == CNT_FULL) begin
                                sda_oe <= 1'b0;
                                mack   <= 1'b0;
                                state  <= ST_WAIT_MACK;
                            end else begin
                                txsh   <= txsh << 1;
                                sda_oe <= !txsh[BYTE_W-2];
                            end
                        end
                    end
                    ST_WAIT_MACK: begin
                        if (scl_rise) begin
                            mack <= !sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                state     <= ST_TX;
                                bitcnt    <= '0;
                                txsh      <= rd_byte;
                                sda_oe    <= !rd_byte[BYTE_W-1];
                                be_rd_stb <= be_sel;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R2: a START always lands in a fresh address phase.
    p_start_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ADDR) && (bitcnt == '0) && (be_sel == '0));

    // R4: an accepted address drives the acknowledge on the next cycle.
    p_ack_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bitcnt == CNT_FULL && dec_ack)
        |=> (sda_oe && state == ST_ACK));

    // R5: the open-drain enable never moves while SCL is high.
    p_oe_on_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R8: a busy memory never lets an address reach the acknowledge state.
    p_busy_noack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bitcnt == CNT_FULL && nv_busy)
        |=> (state == ST_IDLE && !sda_oe));

    // R9: a STOP leaves the line released with nothing selected.
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE && !sda_oe && be_sel == '0));

    // R6: the bit counter never passes one full byte.
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= CNT_FULL);
endmodule

// File: rtl/twowire_preamble_slave.sv
// Top of the two-wire slave front end. Synchronises SCL and SDA, decodes
// the function preamble and strap match, and frames bytes to three back ends.
// Assumes clk runs at least 8x the SCL rate and the pads are external.
module twowire_preamble_slave
    import tw_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] PRE_TEMP    = 4'b0011,
    parameter logic [3:0] PRE_MEM     = 4'b1010,
    parameter logic [3:0] PRE_UTIL    = 4'b0110
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_oe,
    input  logic [2:0]  dev_sel,
    input  logic        nv_busy,
    output logic [2:0]  be_sel,
    output logic [2:0]  be_wr_stb,
    output logic [2:0]  be_rd_stb,
    output logic [7:0]  wr_data,
    output logic        wr_first,
    input  logic [23:0] be_rdata,
    output logic [3:0]  addr_code,
    output logic        be_stop
);
    localparam int NLINES   = 2;
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

    logic [NLINES-1:0]          pins;
    logic [NLINES-1:0]          lvl;
    logic [NLINES-1:0]          prev;
    logic [BYTE_W-1:0]          addr_byte;
    logic [NUM_PORTS-1:0]       dec_hit;
    logic                       dec_ack;

    assign pins[LINE_SCL] = scl_in;
    assign pins[LINE_SDA] = sda_in;

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        tw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pins[g]),
            .lvl   (lvl[g]),
            .prev  (prev[g])
        );
    end

    tw_addr_decode #(
        .PRE_TEMP (PRE_TEMP),
        .PRE_MEM  (PRE_MEM),
        .PRE_UTIL (PRE_UTIL)
    ) u_dec (
        .addr_byte (addr_byte),
        .dev_sel   (dev_sel),
        .nv_busy   (nv_busy),
        .hit       (dec_hit),
        .ack       (dec_ack)
    );

    tw_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (lvl[LINE_SCL]),
        .scl_q     (prev[LINE_SCL]),
        .sda_s     (lvl[LINE_SDA]),
        .sda_q     (prev[LINE_SDA]),
        .dec_hit   (dec_hit),
        .dec_ack   (dec_ack),
        .nv_busy   (nv_busy),
        .be_rdata  (be_rdata),
        .addr_byte (addr_byte),
        .sda_oe    (sda_oe),
        .be_sel    (be_sel),
        .be_wr_stb (be_wr_stb),
        .be_rd_stb (be_rd_stb),
        .wr_data   (wr_data),
        .wr_first  (wr_first),
        .addr_code (addr_code),
        .be_stop   (be_stop)
    );
endmodule

// File: tb/tb_twowire_preamble_slave.sv
module tb_twowire_preamble_slave;
    localparam int W = 6;      // system clocks per SCL quarter
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        nv_busy = 1'b0;
    logic [2:0]  dev_sel = 3'b101;
    logic        sda_oe;
    logic [2:0]  be_sel, be_wr_stb, be_rd_stb;
    logic [7:0]  wr_data;
    logic        wr_first;
    logic [3:0]  addr_code;
    logic        be_stop;
    logic [7:0]  temp_q = 8'hC0;
    logic [7:0]  mem_q  = 8'h40;
    logic        sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0, rd_cnt = 0, stop_cnt = 0;
    logic [2:0] last_port = '0;
    logic [7:0] last_data = '0;
    logic       last_first = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    twowire_preamble_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .dev_sel   (dev_sel),
        .nv_busy   (nv_busy),
        .be_sel    (be_sel),
        .be_wr_stb (be_wr_stb),
        .be_rd_stb (be_rd_stb),
        .wr_data   (wr_data),
        .wr_first  (wr_first),
        .be_rdata  ({8'h5A, mem_q, temp_q}),
        .addr_code (addr_code),
        .be_stop   (be_stop)
    );

    // Back-end models: advance the read pointer on each fetch strobe.
    always @(posedge clk) begin
        if (be_rd_stb[0]) temp_q <= temp_q + 8'd1;
        if (be_rd_stb[1]) mem_q  <= mem_q + 8'd1;
    end

    // Observe strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (|be_wr_stb) begin
                wr_cnt++;
                last_port  = be_wr_stb;
                last_data  = wr_data;
                last_first = wr_first;
            end
            if (|be_rd_stb) rd_cnt++;
            if (be_stop) stop_cnt++;
        end
    end

    // Vector: {addr[7:0], data[7:0], exp_ack, port[1:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {8'h3A, 8'h11, 1'b1, 2'd0},
        {8'hAA, 8'h22, 1'b1, 2'd1},
        {8'h62, 8'h33, 1'b1, 2'd2},
        {8'h38, 8'h44, 1'b0, 2'd0},
        {8'hA2, 8'h55, 1'b0, 2'd0},
        {8'h5A, 8'h66, 1'b0, 2'd0},
        {8'hAA, 8'h80, 1'b1, 2'd1},
        {8'h6E, 8'h01, 1'b1, 2'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic r);
        m_sda = b;
        wt(W);
        m_scl = 1'b1;
        wt(W);
        r = sda_bus;
        wt(W);
        m_scl = 1'b0;
        wt(W);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(W);
        m_scl = 1'b1; wt(W);
        m_sda = 1'b0; wt(W);
        m_scl = 1'b0; wt(W);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(W);
        m_scl = 1'b1; wt(W);
        m_sda = 1'b1; wt(2*W);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, r);
            v[i] = r;
        end
        clock_bit(!give_ack, r);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic       a;
        logic       r;
        logic [7:0] v;
        int         w0, s0, r0;

        wt(5);
        rst_n = 1'b1;
        wt(3);
        chk("R9 reset sda_oe", sda_oe, 0);
        chk("R9 reset be_sel", be_sel, 0);

        // R1: traffic before any START is ignored
        m_scl = 1'b0; wt(W);
        w0 = wr_cnt;
        send_byte(8'h3A, a);
        chk("R1 no ack before START", a, 0);
        send_byte(8'h11, a);
        chk("R1 no strobe before START", wr_cnt - w0, 0);
        bus_stop();

        // Table walk: decode, ack and single-byte write per address
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] ad, dt;
            logic       ea;
            logic [1:0] pt;
            {ad, dt, ea, pt} = VEC[k];
            w0 = wr_cnt;
            s0 = stop_cnt;
            bus_start();
            send_byte(ad, a);
            chk("R3 address ack", a, ea);
            if (ea) begin
                chk("R10 addr_code", addr_code, ad[3:0]);
                chk("R3 be_sel", be_sel, 3'b001 << pt);
            end
            send_byte(dt, a);
            chk("R6 data ack", a, ea);
            chk("R6 write count", wr_cnt - w0, ea ? 1 : 0);
            if (ea) begin
                chk("R6 write data", last_data, dt);
                chk("R6 write port", last_port, 3'b001 << pt);
                chk("R6 wr_first", last_first, 1);
            end
            bus_stop();
            chk("R9 be_stop pulse", stop_cnt - s0, ea ? 1 : 0);
            chk("R9 sel cleared", be_sel, 0);
        end

        // R6/R4: two-byte write, second byte not first, ack released
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h01, a);
        chk("R4 ack released after 9th clock", sda_oe, 0);
        send_byte(8'h02, a);
        chk("R6 second byte acked", a, 1);
        chk("R6 second byte data", last_data, 8'h02);
        chk("R6 second byte not first", last_first, 0);
        chk("R6 two strobes", wr_cnt - w0, 2);
        bus_stop();

        // R7: sequential memory read, ACK twice then NoACK
        r0 = rd_cnt;
        s0 = stop_cnt;
        bus_start();
        send_byte(8'hAB, a);
        chk("R7 read address ack", a, 1);
        recv_byte(1'b1, v);
        chk("R7 read byte 0", v, 8'h40);
        recv_byte(1'b1, v);
        chk("R7 read byte 1", v, 8'h41);
        recv_byte(1'b0, v);
        chk("R7 read byte 2", v, 8'h42);
        chk("R7 released after NoACK", sda_oe, 0);
        chk("R7 fetch count", rd_cnt - r0, 3);
        clock_bit(1'b1, r);
        chk("R7 idle after NoACK", r, 1);
        bus_stop();
        chk("R9 stop after read", stop_cnt - s0, 1);

        // R2: selective read via repeated START
        w0 = wr_cnt;
        s0 = stop_cnt;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h05, a);
        bus_start();
        chk("R2 sel cleared by repeated START", be_sel, 0);
        send_byte(8'h3B, a);
        chk("R2 readdress ack", a, 1);
        chk("R2 temp selected", be_sel, 3'b001);
        recv_byte(1'b0, v);
        chk("R7 temp read byte", v, 8'hC0);
        chk("R2 pointer write only", wr_cnt - w0, 1);
        bus_stop();
        chk("R9 one stop pulse", stop_cnt - s0, 1);

        // R2: START in the middle of a data byte
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hAA, a);
        clock_bit(1'b1, r);
        clock_bit(1'b0, r);
        clock_bit(1'b1, r);
        clock_bit(1'b0, r);
        bus_start();
        send_byte(8'h3A, a);
        chk("R2 mid-byte restart ack", a, 1);
        send_byte(8'h77, a);
        chk("R2 partial byte dropped", wr_cnt - w0, 1);
        chk("R2 new data", last_data, 8'h77);
        chk("R2 new port", last_port, 3'b001);
        bus_stop();

        // R8: busy memory blocks every address, then recovers
        nv_busy = 1'b1;
        bus_start();
        send_byte(8'hAA, a);
        chk("R8 busy memory nack", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'h3A, a);
        chk("R8 busy temp nack", a, 0);
        bus_stop();
        nv_busy = 1'b0;
        bus_start();
        send_byte(8'hAA, a);
        chk("R8 ack after busy clears", a, 1);
        bus_stop();

        finish_run();
    end
endmodule